// File: doc/BRIEF.md
# Bus Controller Outbound Data Word Queue

This block holds the data words a bus controller will send in its next message. The host pushes 16-bit words through a write port, either ahead of the message or while it is in progress. The word serializer takes the oldest word at the start of each word's transmit window. It also raises a strobe at the mid-sync point of that window. If the queue holds no word at that strobe, the block raises an underrun pulse. A mode command that carries one data word takes that word from the same queue.

The queue holds up to 32 words. A small state machine tracks its occupancy using three states. `ST_EMPTY` means no word is held. `ST_PARTIAL` means between one word and one less than capacity. `ST_FULL` means all slots are in use. The transitions are:
- push-from-empty: `ST_EMPTY` to `ST_PARTIAL`
- fill: `ST_PARTIAL` to `ST_FULL`
- drain: `ST_PARTIAL` to `ST_EMPTY`
- pop-from-full: `ST_FULL` to `ST_PARTIAL`
- flush: any state to `ST_EMPTY`

The block discards its whole content in two cases: at master reset, and in the cycle when the message ends with either the good-message flag or the error flag. The next message therefore always starts with the full capacity free.

Top module: `bc_txdata_fifo`

## Requirements
- R1: While the active-low reset `rst_n` is low, `empty` is 1 and `full`, `underrun` and `overflow` are 0.
- R2: Words leave in the order they were accepted. While `empty` is 0, `rd_data` shows the oldest held word. A clock edge with `rd_en` high removes that word.
- R3: Capacity is 32 words. `empty` and `full` are registered and reflect the occupancy after each clock edge. After 32 accepted pushes `full` is 1. With 1 to 31 words held, both flags are 0 (state `ST_PARTIAL`).
- R4: A push while `full` is 1 is dropped, even if a pop happens in the same cycle, and the held words are unchanged. `overflow` goes to 1 after that edge and stays at 1 until a flush or a reset.
- R5: A push and a pop in the same cycle, with the queue neither empty nor full, are both performed and the occupancy is unchanged.
- R6: A clock edge with `msg_valid` or `msg_error` high empties the queue and clears `overflow`. Any push or pop in that same cycle is discarded.
- R7: If `midsync_stb` is high at an edge while `empty` is 1, `underrun` is 1 for exactly the following cycle. This holds even when a push arrives in that same cycle. Otherwise `underrun` is 0.
- R8: A pop while empty is ignored. The next word pushed is the next word shown on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| wr_en | input | 1 | Host push request |
| wr_data | input | 16 | Host data word |
| rd_en | input | 1 | Serializer pop request |
| rd_data | output | 16 | Oldest held word (show-ahead) |
| midsync_stb | input | 1 | Mid-sync deadline strobe of the current word window |
| msg_valid | input | 1 | Message ended without error |
| msg_error | input | 1 | Message ended with an error |
| empty | output | 1 | No word held |
| full | output | 1 | All 32 slots in use |
| underrun | output | 1 | One-cycle pulse: deadline reached with no word present |
| overflow | output | 1 | Sticky: a push was dropped because the queue was full |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- the occupancy never exceeds capacity;
- `empty` and `full` are never both set;
- a flush always lands in `ST_EMPTY`;
- a simultaneous push and pop leaves the occupancy unchanged;
- `overflow` is set after a dropped push and is kept until a flush;
- `underrun` follows a deadline that finds the queue empty.

Other behaviour can only be shown by the bench's scenarios, because it depends on the data words themselves:
- word order over every fill level from 1 to 32;
- that a dropped push leaves the held words intact;
- that a flush discards a push made in the same cycle;
- that a pop on an empty queue does not disturb the pointers.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/txf_occupancy_fsm.sv
module txf_occupancy_fsm
    import txf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic       rd_req,
    input  logic       flush,
    output logic       wr_ok,
    output logic       rd_ok,
    output logic       empty,
    output logic       full,
    output occ_state_t state
);

    occ_state_t    state_nxt;
    logic [CW-1:0] count;
    logic [CW-1:0] count_nxt;

    // Accept decisions depend only on registered state.
    always_comb begin
        wr_ok = wr_req && (state != ST_FULL) && !flush;
        rd_ok = rd_req && (state != ST_EMPTY) && !flush;
    end

    always_comb begin
        count_nxt = count;
        if (flush) begin
            count_nxt = '0;
        end else if (wr_ok && !rd_ok) begin
            count_nxt = count + CW'(1);
        end else if (rd_ok && !wr_ok) begin
            count_nxt = count - CW'(1);
        end
    end

    // Next-state logic: named transitions.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                // push-from-empty
                if (wr_ok) begin
                    state_nxt = (count_nxt == CW'(DEPTH)) ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                if (count_nxt == '0) begin
                    state_nxt = ST_EMPTY;          // drain
                end else if (count_nxt == CW'(DEPTH)) begin
                    state_nxt = ST_FULL;           // fill
                end
            end
            ST_FULL: begin
                // pop-from-full
                if (rd_ok) begin
                    state_nxt = (count_nxt == '0) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            default: state_nxt = ST_EMPTY;
        endcase
        if (flush) begin
            state_nxt = ST_EMPTY;                  // flush
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state)
            ST_EMPTY:   empty = 1'b1;
            ST_PARTIAL: ;
            ST_FULL:    full = 1'b1;
            default:    empty = 1'b1;
        endcase
    end

    p_cap_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    p_full_matches_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (count == CW'(DEPTH)));

    p_rw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok) |=> $stable(count));

    p_flush_lands_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == ST_EMPTY));

endmodule

// File: rtl/txf_storage.sv
module txf_storage #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // One write-enabled register per slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == AW'(i))) begin
                slot[i] <= din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    assign dout = slot[rd_ptr];

    p_flush_resets_ptrs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (wr_ptr == rd_ptr));

endmodule

// File: rtl/txf_guard.sv
module txf_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic full,
    input  logic empty,
    input  logic deadline,
    input  logic flush,
    output logic underrun,
    output logic overflow
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            underrun <= 1'b0;
            overflow <= 1'b0;
        end else begin
            underrun <= deadline && empty;
            if (flush) begin
                overflow <= 1'b0;
            end else if (wr_req && full) begin
                overflow <= 1'b1;
            end
        end
    end

    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !flush) |=> overflow);

    p_underrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(deadline));

endmodule

// File: rtl/bc_txdata_fifo.sv
module bc_txdata_fifo
    import txf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             midsync_stb,
    input  logic             msg_valid,
    input  logic             msg_error,
    output logic             empty,
    output logic             full,
    output logic             underrun,
    output logic             overflow
);

    logic       flush;
    logic       wr_ok;
    logic       rd_ok;
    occ_state_t occ_state;

    assign flush = msg_valid || msg_error;

    txf_occupancy_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_en),
        .rd_req (rd_en),
        .flush  (flush),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .empty  (empty),
        .full   (full),
        .state  (occ_state)
    );

    txf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_ok),
        .pop   (rd_ok),
        .flush (flush),
        .din   (wr_data),
        .dout  (rd_data)
    );

    txf_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_en),
        .full     (full),
        .empty    (empty),
        .deadline (midsync_stb),
        .flush    (flush),
        .underrun (underrun),
        .overflow (overflow)
    );

    p_msg_end_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !overflow));

    p_underrun_when_dry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (midsync_stb && empty) |=> underrun);

    p_no_pop_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> empty);

    p_state_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_state inside {ST_EMPTY, ST_PARTIAL, ST_FULL});

endmodule

// File: tb/bc_txdata_fifo_bench.sv
module bc_txdata_fifo_bench;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        midsync_stb = 1'b0;
    logic        msg_valid = 1'b0;
    logic        msg_error = 1'b0;
    logic        empty, full, underrun, overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bc_txdata_fifo u_bc_txdata_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .midsync_stb(midsync_stb),
        .msg_valid(msg_valid), .msg_error(msg_error), .empty(empty),
        .full(full), .underrun(underrun), .overflow(overflow)
    );

    function automatic logic [15:0] pat_a(input int n, input int i);
        return 16'(16'h4000 + n * 64 + i);
    endfunction

    function automatic logic [15:0] pat_b(input int n, input int i);
        return 16'(16'hC000 + n * 64 + i);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [15:0] d, input logic r,
                       input logic m, input logic v, input logic e);
        wr_en = w; wr_data = d; rd_en = r;
        midsync_stb = m; msg_valid = v; msg_error = e;
        @(posedge clk);
        #2;
        wr_en = 0; rd_en = 0; midsync_stb = 0; msg_valid = 0; msg_error = 0;
    endtask

    task automatic flush_q();
        cyc(0, '0, 0, 0, 1, 0);
    endtask

    task automatic fill(input int n, input int tag);
        for (int i = 0; i < n; i++) cyc(1, pat_a(tag, i), 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        #35;
        check("R1 empty", 16'(empty), 16'd1);
        check("R1 full", 16'(full), 16'd0);
        check("R1 underrun", 16'(underrun), 16'd0);
        check("R1 overflow", 16'(overflow), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;

        // R2/R3: every fill level, fill then drain in order
        for (int n = 1; n <= DEPTH; n++) begin
            flush_q();
            for (int i = 0; i < n; i++) begin
                cyc(1, pat_a(n, i), 0, 0, 0, 0);
                check("R3 empty after push", 16'(empty), 16'd0);
                check("R3 full level", 16'(full), 16'((i + 1) == DEPTH));
            end
            for (int i = 0; i < n; i++) begin
                check("R2 order", rd_data, pat_a(n, i));
                cyc(0, '0, 1, 0, 0, 0);
                check("R3 full after pop", 16'(full), 16'd0);
            end
            check("R3 empty after drain", 16'(empty), 16'd1);
        end

        // R4: push into full is dropped, overflow sticky
        flush_q();
        fill(DEPTH, 7);
        for (int x = 0; x < 3; x++) cyc(1, 16'hDEAD, 0, 0, 0, 0);
        check("R4 overflow set", 16'(overflow), 16'd1);
        check("R4 still full", 16'(full), 16'd1);
        for (int i = 0; i < DEPTH; i++) begin
            check("R4 contents intact", rd_data, pat_a(7, i));
            cyc(0, '0, 1, 0, 0, 0);
        end
        check("R4 overflow sticky", 16'(overflow), 16'd1);
        check("R4 empty after drain", 16'(empty), 16'd1);
        cyc(0, '0, 0, 0, 0, 1);
        check("R6 error flag clears overflow", 16'(overflow), 16'd0);

        // R4: push and pop together while full -> only the pop happens
        fill(DEPTH, 9);
        cyc(1, 16'hBEEF, 1, 0, 0, 0);
        check("R4 full rw leaves partial", 16'(full), 16'd0);
        check("R4 full rw overflow", 16'(overflow), 16'd1);
        for (int i = 1; i < DEPTH; i++) begin
            check("R4 full rw contents", rd_data, pat_a(9, i));
            cyc(0, '0, 1, 0, 0, 0);
        end
        check("R4 full rw drained", 16'(empty), 16'd1);

        // R5: simultaneous push/pop at every partial level
        for (int k = 1; k < DEPTH; k++) begin
            flush_q();
            fill(k, k);
            for (int j = 0; j < 5; j++) begin
                check("R5 rw data", rd_data, (j < k) ? pat_a(k, j) : pat_b(k, j - k));
                cyc(1, pat_b(k, j), 1, 0, 0, 0);
                check("R5 not empty", 16'(empty), 16'd0);
                check("R5 not full", 16'(full), 16'd0);
            end
            for (int j = 5; j < k + 5; j++) begin
                check("R5 remaining", rd_data, (j < k) ? pat_a(k, j) : pat_b(k, j - k));
                cyc(0, '0, 1, 0, 0, 0);
            end
            check("R5 level preserved", 16'(empty), 16'd1);
        end

        // R6: flush with push in same cycle discards the push
        flush_q();
        fill(5, 3);
        cyc(1, 16'h5555, 1, 0, 1, 0);
        check("R6 valid flag empties", 16'(empty), 16'd1);
        cyc(1, 16'h1111, 0, 0, 0, 0);
        check("R6 pointer restart", rd_data, 16'h1111);
        cyc(0, '0, 1, 0, 0, 0);
        check("R6 dropped push absent", 16'(empty), 16'd1);

        // R7: underrun pulse
        cyc(0, '0, 0, 1, 0, 0);
        check("R7 underrun on empty", 16'(underrun), 16'd1);
        cyc(0, '0, 0, 0, 0, 0);
        check("R7 single cycle pulse", 16'(underrun), 16'd0);
        cyc(1, 16'h2222, 0, 1, 0, 0);
        check("R7 late push still underruns", 16'(underrun), 16'd1);
        cyc(0, '0, 0, 1, 0, 0);
        check("R7 no underrun when present", 16'(underrun), 16'd0);
        cyc(0, '0, 1, 0, 0, 0);

        // R8: pop on empty is ignored
        for (int x = 0; x < 4; x++) cyc(0, '0, 1, 0, 0, 0);
        check("R8 still empty", 16'(empty), 16'd1);
        cyc(1, 16'h1234, 0, 0, 0, 0);
        check("R8 next word shown", rd_data, 16'h1234);
        check("R8 not empty", 16'(empty), 16'd0);
        cyc(0, '0, 1, 0, 0, 0);
        check("R8 empty again", 16'(empty), 16'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule